// File: doc/BRIEF.md
# Dual-Register Direct Digital Synthesis Core

This core builds a periodic waveform code from a master clock. It uses a 28-bit phase accumulator. On every enabled clock edge the accumulator adds one of two stored frequency tuning words, so one tuning step equals the master clock rate divided by 2^28. One of two stored 12-bit phase offsets is added to the top 12 accumulator bits. The resulting phase drives one of two shapes: a quarter-wave sine table, or a linear triangle fold. Either one yields a registered 10-bit code, and a DAC outside the block turns that code into an analog level.

Two pins pick the active frequency word and the active phase word. Toggling these pins gives frequency shift keying and phase shift keying with no break in the accumulator. A square output follows the phase MSB, and it can be divided by two. The four tuning words are loaded through a parallel port made of a 2-bit target code, a data bus and a strobe. A clear input resets the phase and parks the output at mid-scale. A sleep input freezes the waveform while the stored words stay intact and can still be written.

Top module: `dds_core`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, `wave_out` is 512 and `sign_out` is 0. All four tuning words read as zero, so with no writes the phase stays at 0.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored into the word picked by `wr_sel`: 0 = frequency word A, 1 = frequency word B, 2 = phase word A (bits 11:0), 3 = phase word B (bits 11:0). The new value is used from the following edge onward.
- R3: On each clock edge with neither clear nor sleep, the accumulator adds word A if `fsel` is 0, or word B if `fsel` is 1, modulo 2^28.
- R4: The phase used by the output is (accumulator bits 27:16 + phase word) mod 4096. The phase word is A if `psel` is 0 or B if `psel` is 1. A pin change is applied at the next edge.
- R5: With `tri_mode` low, the `wave_out` registered at an edge lies within 3 codes of round(511.5 + 511.5·sin(2π(ph+0.5)/4096)), where ph is the phase formed before that edge.
- R6: With `tri_mode` high, `wave_out` equals t for t = ph>>1 below 1024, and 2047 − t otherwise.
- R7: With `div2_en` low, `sign_out` equals bit 11 of the phase that was registered with the current output.
- R8: With `div2_en` high, `sign_out` is a toggle flop that changes once at each rising edge of that registered phase MSB, which gives half the frequency.
- R9: An edge with `acc_clr` high sets the accumulator to 0, `wave_out` to 512 and both sign state bits to 0. The tuning words are kept.
- R10: An edge with `sleep` high and `acc_clr` low leaves the accumulator, `wave_out` and `sign_out` state unchanged. Register writes still take effect.
- R11: When `acc_clr` and `sleep` are both high, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the tuning words |
| wr_sel | input | 2 | Target word code (0 freq A, 1 freq B, 2 phase A, 3 phase B) |
| wr_data | input | 28 | Write data; phase words take bits 11:0 |
| fsel | input | 1 | Active frequency word select |
| psel | input | 1 | Active phase word select |
| tri_mode | input | 1 | 1 = triangle shape, 0 = sine |
| div2_en | input | 1 | 1 = square output divided by two |
| acc_clr | input | 1 | Clears phase and parks output at mid-scale |
| sleep | input | 1 | Freezes the waveform |
| wave_out | output | 10 | Registered waveform code |
| sign_out | output | 1 | Square output from the phase MSB |

## Verification
The case that needs the most care is a write landing on the active word in the same cycle that `fsel` or `psel` switches to that word. The edge at which the switch happens must still use the old stored value, and the following edge must use the new one. Directed steps write frequency word B while switching `fsel` to it in the same cycle. The random phase mixes writes, select toggles, sleep and clear, which also produces clear and sleep together. A cycle-accurate bench model compares every output against a real-valued sine and an integer triangle, and it updates its stored words on the same edge as the design.

// File: rtl/dds_core.sv
`timescale 1ns/1ps
module dds_core #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             fsel,
  input  logic             psel,
  input  logic             tri_mode,
  input  logic             div2_en,
  input  logic             acc_clr,
  input  logic             sleep,
  output logic [OUT_W-1:0] wave_out,
  output logic             sign_out
);
  localparam int QA = PH_W - 2;
  localparam int MW = OUT_W - 1;
  localparam int AMP = (1 << MW) - 1;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1) << MW;

  function automatic logic [MW-1:0] qmag(input int i);
    logic [63:0] p, q, num, den, big;
    big = 64'(1) << PH_W;
    p   = 64'(2 * i + 1);
    q   = p * (big - p);
    num = 64'(AMP) * 64'd16 * q;
    den = 64'd5 * big * big - 64'd4 * q;
    return MW'((num + den / 64'd2) / den);
  endfunction

  logic [MW-1:0] qtab [2**QA];
  for (genvar gi = 0; gi < 2**QA; gi++) begin : g_qtab
    assign qtab[gi] = qmag(gi);
  end

  logic [ACC_W-1:0] freq_a, freq_b, acc;
  logic [PH_W-1:0]  poff_a, poff_b;
  logic             msb_q, tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_a <= '0;
      freq_b <= '0;
      poff_a <= '0;
      poff_b <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: freq_a <= wr_data;
        2'd1: freq_b <= wr_data;
        2'd2: poff_a <= wr_data[PH_W-1:0];
        default: poff_b <= wr_data[PH_W-1:0];
      endcase
    end
  end

  wire [ACC_W-1:0] f_act = fsel ? freq_b : freq_a;
  wire [PH_W-1:0]  p_act = psel ? poff_b : poff_a;
  wire [PH_W-1:0]  ph    = acc[ACC_W-1 -: PH_W] + p_act;

  wire             half  = ph[PH_W-1];
  wire [QA-1:0]    qaddr = ph[PH_W-2] ? ~ph[QA-1:0] : ph[QA-1:0];
  wire [OUT_W-1:0] mag   = {1'b0, qtab[qaddr]};
  wire [OUT_W-1:0] sine  = half ? (MID - OUT_W'(1) - mag) : (MID + mag);
  wire [OUT_W-1:0] tseg  = ph[PH_W-2 -: OUT_W];
  wire [OUT_W-1:0] tri_w = half ? ~tseg : tseg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      wave_out <= MID;
      msb_q    <= 1'b0;
      tgl_q    <= 1'b0;
    end else if (acc_clr) begin
      acc      <= '0;
      wave_out <= MID;
      msb_q    <= 1'b0;
      tgl_q    <= 1'b0;
    end else if (!sleep) begin
      acc      <= acc + f_act;
      wave_out <= tri_mode ? tri_w : sine;
      msb_q    <= half;
      if (half && !msb_q) tgl_q <= ~tgl_q;
    end
  end

  assign sign_out = div2_en ? tgl_q : msb_q;

  assert_clr_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(acc_clr) |-> (wave_out == MID) && (acc == '0) && !sign_out);

  assert_clr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(acc_clr) && $past(sleep) |-> (acc == '0));

  assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(sleep) && !$past(acc_clr) |-> $stable(acc) && $stable(wave_out) && $stable(tgl_q));

  assert_wr_freq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en) && ($past(wr_sel) == 2'd1) |-> freq_b == $past(wr_data));

  assert_div2_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && div2_en && $past(div2_en) && !$past(acc_clr) && !$stable(sign_out) |-> $rose(msb_q));
endmodule

// File: tb/dds_core_tb.sv
`timescale 1ns/1ps
module dds_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [27:0] wr_data = '0;
  logic        fsel = 1'b0, psel = 1'b0, tri_mode = 1'b0, div2_en = 1'b0;
  logic        acc_clr = 1'b0, sleep = 1'b0;
  logic [9:0]  wave_out;
  logic        sign_out;

  int checks = 0;
  int fails = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string dir_tag = "";

  always #10 clk = ~clk;

  dds_core u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fsel(fsel), .psel(psel), .tri_mode(tri_mode), .div2_en(div2_en),
    .acc_clr(acc_clr), .sleep(sleep), .wave_out(wave_out), .sign_out(sign_out)
  );

  function automatic int exp_sine(input int ph);
    real a;
    a = 2.0 * 3.14159265358979 * (real'(ph) + 0.5) / 4096.0;
    return $rtoi($floor(511.5 + 511.5 * $sin(a) + 0.5));
  endfunction

  function automatic int exp_tri(input int ph);
    int t;
    t = ph >> 1;
    return (t < 1024) ? t : 2047 - t;
  endfunction

  logic [27:0] m_acc, m_f0, m_f1;
  logic [11:0] m_p0, m_p1, m_ph;
  int          m_wave;
  bit          m_sine, m_msb, m_tgl;
  string       m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = '0; m_f0 = '0; m_f1 = '0; m_p0 = '0; m_p1 = '0;
      m_wave = 512; m_sine = 1'b0; m_msb = 1'b0; m_tgl = 1'b0; m_tag = "R1";
    end else begin
      m_ph = m_acc[27:16] + (psel ? m_p1 : m_p0);
      if (acc_clr) begin
        m_acc = '0; m_wave = 512; m_sine = 1'b0; m_msb = 1'b0; m_tgl = 1'b0;
        m_tag = sleep ? "R11" : "R9";
      end else if (sleep) begin
        m_tag = "R10";
      end else begin
        m_acc = m_acc + (fsel ? m_f1 : m_f0);
        m_sine = !tri_mode;
        m_wave = tri_mode ? exp_tri(int'(m_ph)) : exp_sine(int'(m_ph));
        if (m_ph[11] && !m_msb) m_tgl = ~m_tgl;
        m_msb = m_ph[11];
        m_tag = tri_mode ? "R6" : "R5";
      end
      if (dir_tag != "" && !acc_clr && !sleep) m_tag = dir_tag;
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_f0 = wr_data;
          2'd1: m_f1 = wr_data;
          2'd2: m_p0 = wr_data[11:0];
          default: m_p1 = wr_data[11:0];
        endcase
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      check(m_tag, int'(wave_out), m_wave, m_sine ? 3 : 0);
      check(div2_en ? "R8" : "R7", int'(sign_out), int'(div2_en ? m_tgl : m_msb), 0);
    end
  end

  task automatic tick();
    @(posedge clk);
    #3;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [27:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    tick();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", int'(wave_out), 512, 0);
    check("R1", int'(sign_out), 0, 0);
    #3 rst_n = 1'b1;
    tick();
    chk_on = 1'b1;
    dir_tag = "R1"; run(4);

    dir_tag = "R2";
    wr(2'd0, 28'h0400000);
    wr(2'd2, 28'h0000123);
    run(20);
    fsel = 1'b1;
    wr(2'd1, 28'h0A00000);
    run(20);

    dir_tag = "R3";
    wr(2'd1, 28'hFF00000);
    for (int i = 0; i < 40; i++) begin fsel = $urandom % 2; tick(); end
    fsel = 1'b0;

    dir_tag = "R4";
    wr(2'd3, 28'h0000800);
    for (int i = 0; i < 40; i++) begin psel = $urandom % 2; tick(); end
    psel = 1'b0;

    dir_tag = "";
    tri_mode = 1'b1;
    wr(2'd0, 28'h1000000);
    run(300);
    tri_mode = 1'b0;

    div2_en = 1'b1;
    wr(2'd0, 28'h0800000);
    run(600);

    acc_clr = 1'b1; run(5);
    acc_clr = 1'b0; run(10);
    sleep = 1'b1;
    wr(2'd0, 28'h0123456);
    run(8);
    sleep = 1'b0; run(20);
    acc_clr = 1'b1; sleep = 1'b1; run(4);
    acc_clr = 1'b0; sleep = 1'b0; run(10);
    div2_en = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      fsel = $urandom % 2;
      psel = $urandom % 2;
      if ($urandom % 60 == 0) tri_mode = ~tri_mode;
      if ($urandom % 80 == 0) div2_en = ~div2_en;
      sleep = ($urandom % 10 == 0);
      acc_clr = ($urandom % 40 == 0);
      if ($urandom % 8 == 0) begin
        wr_en = 1'b1;
        wr_sel = 2'($urandom % 4);
        wr_data = 28'($urandom >> (4 + $urandom % 8));
      end
      tick();
    end
    acc_clr = 1'b0; sleep = 1'b0;
    run(2);
    finish_up();
  end
endmodule